// File: doc/BRIEF.md
# Packed-BCD Adder with Decimal Adjust

This block adds two bytes in two separate steps. The first step is a plain binary add of both operands plus a carry-in. It records the binary carry out of bit 7 and a half-carry out of bit 3. The second step is optional. It uses the stored half-carry and carry to correct the intermediate sum into a valid two-digit packed-BCD byte, and it produces a decimal carry that stands for the hundreds digit.

The caller picks one of two modes with each request. Raw mode returns the unadjusted binary sum one cycle after the request. Adjust mode shows that same intermediate sum one cycle after the request, then replaces it with the corrected BCD value in the next cycle. The carry-in lets a caller chain byte-wide decimal additions across several bytes.

Top module: `bcd_adj_adder`

## Requirements
- R1: While reset is active, and after it is released with no request, result, carry_out, half_carry, zero and done are all 0.
- R2: A request (in_valid=1) is registered on a clock edge. On the outputs after that edge, result equals (op_a + op_b + carry_in) mod 256, and carry_out is 1 exactly when that sum exceeds 255.
- R3: Half_carry is 1 exactly when op_a[3:0] + op_b[3:0] + carry_in exceeds 15. In adjust mode it keeps this binary value through the correction cycle.
- R4: In the correction cycle, 0x06 is added when the low nibble of the intermediate sum exceeds 9 or the half-carry is set.
- R5: In the correction cycle, 0x60 is also added when the binary carry is set, or when the high nibble exceeds 9 after the 0x06 step, or when the 0x06 step carries out of bit 7. In that case the final carry_out is 1. Otherwise carry_out is 0.
- R6: With adjust_mode=1, the outputs one edge after the request show the raw binary sum with done=0. The corrected value appears one edge later.
- R7: Done is a one-cycle pulse. It rises one edge after a raw-mode request, and two edges after an adjust-mode request.
- R8: Zero is 1 exactly when the displayed 8-bit result is 0x00. In adjust mode this applies to the value after correction.
- R9: A request presented during the correction cycle is ignored. The corrected result stays on the outputs and no further done pulse follows.
- R10: For operands whose four nibbles are each 0 to 9, adjust mode returns the two low decimal digits of op_a + op_b + carry_in as packed BCD, with carry_out=1 exactly when that decimal sum is 100 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry added into bit 0 |
| adjust_mode | input | 1 | 1: add then decimal-adjust; 0: raw binary add |
| result | output | 8 | Sum byte (raw or corrected) |
| carry_out | output | 1 | Binary carry, or decimal carry after correction |
| half_carry | output | 1 | Carry out of bit 3 of the binary add |
| zero | output | 1 | Result is 0x00 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main stimulus is an exhaustive sweep over every pair of valid BCD operands with both carry-in values. This shows that the low-digit and high-digit corrections combine into correct decimal sums. The sweep also checks the intermediate cycle, which shows whether the half-carry and binary carry are taken from the raw add. Three short cases are tried separately:
- Pairs with a low nibble above 9 alone, a half-carry alone, and a high nibble above 9 alone. These tell the three correction triggers apart.
- Raw-mode runs with non-BCD bytes and with wrap-around to 0x00. These separate the binary path and the zero flag from the adjust path.
- A request placed in the correction cycle. This shows that the correction step takes priority over a new request.

// File: rtl/bcd_adj_adder.sv
module bcd_adj_adder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] op_a,
  input  logic [7:0] op_b,
  input  logic       carry_in,
  input  logic       adjust_mode,
  output logic [7:0] result,
  output logic       carry_out,
  output logic       half_carry,
  output logic       zero,
  output logic       done
);

  logic [7:0] res_q;
  logic       cy_q, hc_q, z_q, done_q, pend;

  logic [8:0] bin_sum;
  logic [4:0] low_sum;
  assign bin_sum = {1'b0, op_a} + {1'b0, op_b} + {8'b0, carry_in};
  assign low_sum = {1'b0, op_a[3:0]} + {1'b0, op_b[3:0]} + {4'b0, carry_in};

  logic       lo_fix, hi_fix;
  logic [8:0] step1, step2;
  assign lo_fix = (res_q[3:0] > 4'd9) || hc_q;
  assign step1  = {1'b0, res_q} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix = cy_q || step1[8] || (step1[7:4] > 4'd9);
  assign step2  = {1'b0, step1[7:0]} + (hi_fix ? 9'h060 : 9'h000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= 8'h00;
      cy_q   <= 1'b0;
      hc_q   <= 1'b0;
      z_q    <= 1'b0;
      done_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pend) begin
        res_q  <= step2[7:0];
        cy_q   <= hi_fix | step2[8];
        z_q    <= (step2[7:0] == 8'h00);
        done_q <= 1'b1;
        pend   <= 1'b0;
      end else if (in_valid) begin
        res_q  <= bin_sum[7:0];
        cy_q   <= bin_sum[8];
        hc_q   <= low_sum[4];
        z_q    <= (bin_sum[7:0] == 8'h00);
        done_q <= ~adjust_mode;
        pend   <= adjust_mode;
      end
    end
  end

  assign result     = res_q;
  assign carry_out  = cy_q;
  assign half_carry = hc_q;
  assign zero       = z_q;
  assign done       = done_q;

  a_r7_raw_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !adjust_mode && !pend) |=> done);

  a_r6_adj_two_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && adjust_mode && !pend) |=> (!done ##1 done));

  a_r3_hc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> $stable(half_carry));

  a_r5_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && carry_out) |=> carry_out);

  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && in_valid) |=> ##1 !done);

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (zero == (result == 8'h00)));

endmodule

// File: tb/test_bcd_adj_adder.sv
module test_bcd_adj_adder;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, carry_in = 0, adjust_mode = 0;
  logic [7:0] op_a = 0, op_b = 0;
  logic [7:0] result;
  logic carry_out, half_carry, zero, done;

  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  bcd_adj_adder i_bcd_adj_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .adjust_mode(adjust_mode), .result(result),
    .carry_out(carry_out), .half_carry(half_carry), .zero(zero), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; checks intermediate and (in adjust mode) final outputs
  task automatic run(input int a, input int b, input int ci, input bit adj,
                     input int exp_res, input int exp_cy, input string req);
    int bs, ls;
    bs = a + b + ci;
    ls = (a % 16) + (b % 16) + ci;
    @(negedge clk);
    op_a = a[7:0]; op_b = b[7:0]; carry_in = ci[0]; adjust_mode = adj; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R2 raw sum", result, bs % 256);
    chk("R2 raw carry", carry_out, bs > 255);
    chk("R3 half carry", half_carry, ls > 15);
    chk("R7/R6 done stage1", done, !adj);
    if (!adj) chk("R8 zero raw", zero, (bs % 256) == 0);
    if (adj) begin
      @(negedge clk);
      chk({req, " result"}, result, exp_res);
      chk({req, " carry"}, carry_out, exp_cy);
      chk("R3 half carry kept", half_carry, ls > 15);
      chk("R8 zero adj", zero, exp_res == 0);
      chk("R7 done stage2", done, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset result", result, 0);
    chk("R1 reset flags", {carry_out, half_carry, zero, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {result, carry_out, half_carry, zero, done}, 0);

    run(8'h25, 8'h48, 0, 1, 8'h73, 0, "R4 low>9");
    run(8'h39, 8'h48, 0, 1, 8'h87, 0, "R4 half-carry");
    run(8'h72, 8'h73, 0, 1, 8'h45, 1, "R5 high>9");
    run(8'h99, 8'h99, 0, 1, 8'h98, 1, "R5 binary carry");
    run(8'h95, 8'h05, 0, 1, 8'h00, 1, "R5 high after low step");
    run(8'h50, 8'h50, 0, 1, 8'h00, 1, "R8 zero after adjust");
    run(8'h25, 8'h48, 0, 0, 0, 0, "R2 raw");
    run(8'hF0, 8'h10, 0, 0, 0, 0, "R8 raw wrap");
    run(8'hAB, 8'hCD, 1, 0, 0, 0, "R2 non-BCD carry-in");

    // R9: request in correction cycle ignored
    @(negedge clk);
    op_a = 8'h12; op_b = 8'h34; carry_in = 0; adjust_mode = 1; in_valid = 1;
    @(negedge clk);
    op_a = 8'h77; op_b = 8'h11; adjust_mode = 0;
    @(negedge clk);
    in_valid = 0;
    chk("R9 result kept", result, 8'h46);
    chk("R9 done", done, 1);
    @(negedge clk);
    chk("R9 no second done", done, 0);
    chk("R9 result stable", result, 8'h46);

    // R10 exhaustive decimal sweep
    for (int ci = 0; ci < 2; ci++)
      for (int x = 0; x < 100; x++)
        for (int y = 0; y < 100; y++) begin
          int s, ea, eb, er;
          s  = x + y + ci;
          ea = (x / 10) * 16 + x % 10;
          eb = (y / 10) * 16 + y % 10;
          er = ((s % 100) / 10) * 16 + (s % 10);
          run(ea, eb, ci, 1, er, s >= 100, "R10 decimal");
        end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule